// File: doc/BRIEF.md
# Nine-bit address-filtering serial receiver

This block receives an 11-bit asynchronous character: one low start bit, eight data bits sent least significant bit first, a ninth bit, and a high stop bit. A sample tick from outside, running at sixteen times the bit rate, paces the receiver. While idle, the receiver watches the synchronised line for a high-to-low step. Once a frame has started, it resolves every bit by a two-of-three vote.

The ninth bit carries an address marker for multi-drop links. When filtering is on, only frames whose ninth bit is 1 are accepted, so a node can skip data traffic until it sees an address. A frame is also refused while the previous one is still unacknowledged. An accepted frame loads the data register, the ninth-bit flag and the done flag. A stop bit that votes low raises a sticky error flag. That flag is read and written through bit 7 of the control register, a position it shares with a plain mode bit. A selector bit in a second register decides which of the two bit 7 reaches.

A small register port with a write strobe and combinational read data gives software access.

Top module: `mpu_rx_top`

## Requirements
- R1: After reset, the control register (address 0), the data register (address 1) and the auxiliary register (address 2) all read 0x00. Control bits: 7 mode/error, 5 filter enable, 4 receive enable, 2 ninth-bit flag (read-only), 0 done flag. Auxiliary bit 6 is the error selector.
- R2: While receive enable is 0, a falling edge on the line does not start a frame, and no register changes.
- R3: Each bit is the majority of the samples at tick positions 7, 8 and 9 of its 16-tick period, where position 0 is the tick on which the falling edge is seen. One disagreeing sample among the three does not change the bit. Samples outside those positions have no effect.
- R4: If the start bit votes 1, the receiver drops the attempt, changes no register, and receives the next frame normally.
- R5: When a frame is accepted at the vote of its ninth bit, the data register takes the eight data bits (first bit received in bit 0), the ninth-bit flag takes the ninth bit, and the done flag goes to 1.
- R6: While the done flag is 1, an incoming frame is discarded. The data register and the ninth-bit flag keep their values.
- R7: With filter enable at 1, a frame whose ninth bit is 0 is discarded and the done flag stays 0. A frame whose ninth bit is 1 is accepted.
- R8: A stop bit that votes 0 sets the error flag. A later correctly framed character does not clear it. Only a control write made while the selector is 1 changes it, and the flag takes written bit 7.
- R9: With the selector at 0, control bit 7 reads and writes the mode bit. With the selector at 1, it reads and writes the error flag. Changing the selector alters neither stored value.
- R10: A control write with bit 0 at 0 clears the done flag, and a write with bit 0 at 1 has no effect on it. If a clear and a hardware set fall in the same cycle, the flag ends up at 1.
- R11: After the stop-bit vote, the receiver hunts for a new falling edge. A frame whose start bit immediately follows the previous stop bit is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle sample strobe at 16x bit rate |
| rxd_i | input | 1 | Serial line, idle high |
| reg_addr_i | input | 2 | Register address: 0 control, 1 data, 2 auxiliary |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |

## Verification
Frames are driven slot by slot against the tick, so the bench knows exactly which sample each line value lands on. Single-sample corruption inside the voting window is set against two-sample corruption: the first must leave the bit alone and the second must flip it. A short low pulse on an idle line shows the glitch rejection, and a dropped frame followed at once by a kept one shows that edge hunting resumes. Filter, done-flag and stop-bit variations are combined with selector changes, which separates the acceptance rule from the shared-bit aliasing and from the stickiness of the error flag.

// File: rtl/mpu_rx_pkg.sv
package mpu_rx_pkg;
  localparam int unsigned REG_AW = 2;
  localparam int unsigned REG_DW = 8;
  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_DATA = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_AUX  = 2'd2;
  localparam int unsigned CB_DONE = 0;
  localparam int unsigned CB_NINE = 2;
  localparam int unsigned CB_EN   = 4;
  localparam int unsigned CB_FILT = 5;
  localparam int unsigned CB_MODE = 7;
  localparam int unsigned AB_SEL  = 6;
  typedef enum logic {RX_HUNT, RX_BUSY} rx_state_e;
endpackage

// File: rtl/mpu_rx_sync.sv
module mpu_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= d_i;
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mpu_rx_sampler.sv
module mpu_rx_sampler #(
  parameter int unsigned OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  input  logic run_i,
  output logic fall_o,
  output logic vote_vld_o,
  output logic vote_o
);
  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned MID = OVS / 2;
  localparam logic [CW-1:0] V_LO  = CW'(MID - 1);
  localparam logic [CW-1:0] V_MID = CW'(MID);
  localparam logic [CW-1:0] V_HI  = CW'(MID + 1);
  localparam logic [CW-1:0] C_TOP = CW'(OVS - 1);

  logic [CW-1:0] cnt_q;
  logic          last_q;
  logic [1:0]    early_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= CW'(1);
      last_q  <= 1'b1;
      early_q <= '0;
    end else if (tick_i) begin
      last_q <= line_i;
      if (!run_i) begin
        cnt_q <= CW'(1);  // edge tick was position 0
      end else begin
        cnt_q <= (cnt_q == C_TOP) ? '0 : cnt_q + CW'(1);
        if (cnt_q == V_LO)  early_q[0] <= line_i;
        if (cnt_q == V_MID) early_q[1] <= line_i;
      end
    end
  end

  assign fall_o     = tick_i & last_q & ~line_i;
  assign vote_vld_o = tick_i & run_i & (cnt_q == V_HI);
  assign vote_o     = (early_q[0] & early_q[1]) | (early_q[0] & line_i) |
                      (early_q[1] & line_i);

  // R3
  vote_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vote_vld_o |=> !vote_vld_o);
endmodule

// File: rtl/mpu_rx_fsm.sv
module mpu_rx_fsm
  import mpu_rx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          fall_i,
  input  logic          vote_vld_i,
  input  logic          vote_i,
  output logic          run_o,
  output logic          nine_vld_o,
  output logic [DW-1:0] data_o,
  output logic          nine_o,
  output logic          stop_vld_o,
  output logic          stop_ok_o
);
  localparam int unsigned IW = $clog2(DW + 3);
  localparam logic [IW-1:0] NINE_IDX = IW'(DW + 1);
  localparam logic [IW-1:0] STOP_IDX = IW'(DW + 2);

  rx_state_e     state_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_HUNT;
      idx_q   <= '0;
      shift_q <= '0;
    end else begin
      case (state_q)
        RX_HUNT: if (fall_i && en_i) begin
          state_q <= RX_BUSY;
          idx_q   <= '0;
        end
        RX_BUSY: if (vote_vld_i) begin
          if (idx_q == '0) begin
            if (vote_i) state_q <= RX_HUNT;  // glitch
            else        idx_q   <= IW'(1);
          end else if (idx_q < NINE_IDX) begin
            shift_q <= {vote_i, shift_q[DW-1:1]};
            idx_q   <= idx_q + IW'(1);
          end else if (idx_q == NINE_IDX) begin
            idx_q <= idx_q + IW'(1);
          end else begin
            state_q <= RX_HUNT;
          end
        end
        default: state_q <= RX_HUNT;
      endcase
    end
  end

  assign run_o      = (state_q == RX_BUSY);
  assign nine_vld_o = run_o & vote_vld_i & (idx_q == NINE_IDX);
  assign nine_o     = vote_i;
  assign data_o     = shift_q;
  assign stop_vld_o = run_o & vote_vld_i & (idx_q == STOP_IDX);
  assign stop_ok_o  = vote_i;

  // R4
  glitch_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && vote_vld_i && idx_q == '0 && vote_i) |=> !run_o);
  // R11
  hunt_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_vld_o |=> !run_o);
  // R2
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o && !en_i) |=> !run_o);
endmodule

// File: rtl/mpu_rx_regs.sv
module mpu_rx_regs
  import mpu_rx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              wr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  input  logic              nine_vld_i,
  input  logic [DW-1:0]     data_i,
  input  logic              nine_i,
  input  logic              stop_vld_i,
  input  logic              stop_ok_i,
  output logic              en_o
);
  logic [DW-1:0] buf_q;
  logic rb8_q, done_q, err_q, mode_q, filt_q, en_q, sel_q;
  logic keep, ctrl_wr, aux_wr, err_set;

  assign ctrl_wr = wr_i && (addr_i == ADDR_CTRL);
  assign aux_wr  = wr_i && (addr_i == ADDR_AUX);
  assign keep    = nine_vld_i && !done_q && (!filt_q || nine_i);
  assign err_set = stop_vld_i && !stop_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      rb8_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      mode_q <= 1'b0;
      filt_q <= 1'b0;
      en_q   <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      if (keep) begin
        buf_q <= data_i;
        rb8_q <= nine_i;
      end
      if (keep)                               done_q <= 1'b1;
      else if (ctrl_wr && !wdata_i[CB_DONE])  done_q <= 1'b0;
      if (err_set)                    err_q <= 1'b1;
      else if (ctrl_wr && sel_q)      err_q <= wdata_i[CB_MODE];
      if (ctrl_wr && !sel_q)          mode_q <= wdata_i[CB_MODE];
      if (ctrl_wr) begin
        filt_q <= wdata_i[CB_FILT];
        en_q   <= wdata_i[CB_EN];
      end
      if (aux_wr) sel_q <= wdata_i[AB_SEL];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CB_MODE] = sel_q ? err_q : mode_q;
        rdata_o[CB_FILT] = filt_q;
        rdata_o[CB_EN]   = en_q;
        rdata_o[CB_NINE] = rb8_q;
        rdata_o[CB_DONE] = done_q;
      end
      ADDR_DATA: rdata_o = REG_DW'(buf_q);
      ADDR_AUX:  rdata_o[AB_SEL] = sel_q;
      default:   rdata_o = '0;
    endcase
  end

  assign en_o = en_q;

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[REG_DW-1:0]};

  // R6
  done_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nine_vld_i && done_q) |=> ($stable(buf_q) && $stable(rb8_q)));
  // R7
  filter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nine_vld_i && filt_q && !nine_i && !wr_i) |=> ($stable(buf_q) && $stable(done_q)));
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !(ctrl_wr && sel_q)) |=> err_q);
  // R9
  alias_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_wr && !stop_vld_i) |=> ($stable(mode_q) && $stable(err_q)));
  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keep |=> done_q);
endmodule

// File: rtl/mpu_rx_top.sv
module mpu_rx_top
  import mpu_rx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o
);
  logic line, run, fall, vote_vld, vote, en;
  logic nine_vld, nine, stop_vld, stop_ok;
  logic [DW-1:0] data;

  mpu_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(line));

  mpu_rx_sampler #(.OVS(OVS)) u_samp (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .line_i(line),
    .run_i(run), .fall_o(fall), .vote_vld_o(vote_vld), .vote_o(vote));

  mpu_rx_fsm #(.DW(DW)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .fall_i(fall),
    .vote_vld_i(vote_vld), .vote_i(vote), .run_o(run),
    .nine_vld_o(nine_vld), .data_o(data), .nine_o(nine),
    .stop_vld_o(stop_vld), .stop_ok_o(stop_ok));

  mpu_rx_regs #(.DW(DW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(reg_addr_i), .wr_i(reg_wr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .nine_vld_i(nine_vld),
    .data_i(data), .nine_i(nine), .stop_vld_i(stop_vld),
    .stop_ok_i(stop_ok), .en_o(en));
endmodule

// File: tb/sim_mpu_rx_top.sv
module sim_mpu_rx_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic [1:0] addr = '0;
  logic wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] tdiv = '0;
  logic tick;

  int n_run = 0;
  int n_fail = 0;

  typedef struct { logic [7:0] ctrl; logic [7:0] dat; string tag; } exp_t;
  exp_t sb_q[$];

  logic m_mode = 0, m_err = 0, m_sel = 0, m_filt = 0, m_en = 0;
  logic m_done = 0, m_nine = 0;
  logic [7:0] m_buf = '0;

  always #10 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd0);

  mpu_rx_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata));

  function automatic logic [7:0] ctrl_exp();
    return {(m_sel ? m_err : m_mode), 1'b0, m_filt, m_en, 1'b0, m_nine, 1'b0, m_done};
  endfunction

  function automatic logic [7:0] ctrl_byte(logic b7, logic done_bit);
    return {b7, 1'b0, m_filt, m_en, 3'b000, done_bit};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic check_reg(logic [1:0] a, logic [7:0] exp, string tag);
    logic [7:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wr_ctrl(logic b7, logic filt, logic en, logic done_bit);
    m_filt = filt; m_en = en;
    wr_reg(2'd0, ctrl_byte(b7, done_bit));
    if (m_sel) m_err = b7; else m_mode = b7;
    if (!done_bit) m_done = 1'b0;
  endtask

  task automatic wr_aux(logic s);
    wr_reg(2'd2, {1'b0, s, 6'b0});
    m_sel = s;
  endtask

  task automatic slot();
    @(negedge clk);
    wr = 1'b0;
    while (!tick) @(negedge clk);
  endtask

  task automatic idle_slots(int n);
    for (int i = 0; i < n; i++) begin slot(); rxd = 1'b1; end
  endtask

  // driver: drives one frame and pushes the expected register image
  task automatic send_frame(logic [7:0] d, logic b9, logic stp, int glitch,
                            logic [15:0] flip0, logic clr_at_set, string tag);
    logic [10:0] bits;
    logic keep;
    logic [7:0] dd;
    int votes;
    exp_t e;
    bits = {stp, b9, d, 1'b0};
    if (glitch > 0) begin
      for (int s = 0; s < 16; s++) begin slot(); rxd = (s < glitch) ? 1'b0 : 1'b1; end
    end else begin
      for (int b = 0; b < 11; b++)
        for (int s = 0; s < 16; s++) begin
          slot();
          rxd = bits[b] ^ ((b == 1) ? flip0[s] : 1'b0);
          if (clr_at_set && b == 9 && s == 10) begin
            addr = 2'd0; wdata = ctrl_byte(m_sel ? m_err : m_mode, 1'b0); wr = 1'b1;
          end
        end
    end
    if (m_en && glitch == 0) begin
      votes = int'(flip0[7]) + int'(flip0[8]) + int'(flip0[9]);
      dd = d ^ {7'b0, (votes >= 2)};
      keep = !m_done && (!m_filt || b9);
      if (keep) begin m_buf = dd; m_nine = b9; m_done = 1'b1; end
      else if (clr_at_set) m_done = 1'b0;
      if (!stp) m_err = 1'b1;
    end
    e.ctrl = ctrl_exp(); e.dat = m_buf; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: pops the oldest expectation and compares with the registers
  task automatic sb_check();
    exp_t e;
    logic [7:0] v;
    idle_slots(3);
    e = sb_q.pop_front();
    rd(2'd0, v); check({e.tag, " ctrl"}, v, e.ctrl);
    rd(2'd1, v); check({e.tag, " data"}, v, e.dat);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset values
    check_reg(2'd0, 8'h00, "R1 ctrl");
    check_reg(2'd1, 8'h00, "R1 data");
    check_reg(2'd2, 8'h00, "R1 aux");

    // R2 receiver disabled
    send_frame(8'hA5, 1'b1, 1'b0, 0, '0, 1'b0, "R2 disabled"); sb_check();

    wr_ctrl(1'b0, 1'b0, 1'b1, 1'b1);
    // R5 accepted frame
    send_frame(8'h3C, 1'b0, 1'b1, 0, '0, 1'b0, "R5 keep"); sb_check();
    // R6 done flag still set
    send_frame(8'h77, 1'b1, 1'b1, 0, '0, 1'b0, "R6 discard"); sb_check();

    // R10 write 1 no effect, write 0 clears
    wr_ctrl(1'b0, 1'b0, 1'b1, 1'b1);
    check_reg(2'd0, ctrl_exp(), "R10 write1 keeps");
    wr_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
    check_reg(2'd0, ctrl_exp(), "R10 write0 clears");
    wr_ctrl(1'b0, 1'b0, 1'b1, 1'b1);
    check_reg(2'd0, ctrl_exp(), "R10 write1 no set");

    // R7 address filter
    wr_ctrl(1'b0, 1'b1, 1'b1, 1'b1);
    send_frame(8'h11, 1'b0, 1'b1, 0, '0, 1'b0, "R7 drop"); sb_check();
    send_frame(8'h22, 1'b1, 1'b1, 0, '0, 1'b0, "R7 keep"); sb_check();

    // R11 back-to-back, first dropped by filter
    wr_ctrl(1'b0, 1'b1, 1'b1, 1'b0);
    send_frame(8'h5A, 1'b0, 1'b1, 0, '0, 1'b0, "R11 first");
    send_frame(8'hC3, 1'b1, 1'b1, 0, '0, 1'b0, "R11 second");
    void'(sb_q.pop_front());
    sb_check();

    // R3 majority voting
    wr_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
    send_frame(8'h80, 1'b0, 1'b1, 0, 16'h0100, 1'b0, "R3 one bad sample"); sb_check();
    wr_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
    send_frame(8'h80, 1'b0, 1'b1, 0, 16'h0180, 1'b0, "R3 two bad samples"); sb_check();
    wr_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
    send_frame(8'h40, 1'b0, 1'b1, 0, 16'hF07F, 1'b0, "R3 outside window"); sb_check();

    // R4 start glitch then normal frame
    wr_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
    send_frame(8'h00, 1'b0, 1'b1, 4, '0, 1'b0, "R4 glitch"); sb_check();
    send_frame(8'h99, 1'b0, 1'b1, 0, '0, 1'b0, "R4 after glitch"); sb_check();

    // R8 framing error, sticky
    wr_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
    send_frame(8'h0F, 1'b0, 1'b0, 0, '0, 1'b0, "R8 bad stop"); sb_check();
    wr_aux(1'b1);
    check_reg(2'd0, ctrl_exp(), "R8 error visible");
    wr_ctrl(1'b1, 1'b0, 1'b1, 1'b0);
    send_frame(8'hF0, 1'b0, 1'b1, 0, '0, 1'b0, "R8 good frame keeps error"); sb_check();
    wr_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
    check_reg(2'd0, ctrl_exp(), "R8 cleared by write");

    // R9 aliasing
    wr_aux(1'b0);
    wr_ctrl(1'b1, 1'b0, 1'b1, 1'b1);
    check_reg(2'd0, ctrl_exp(), "R9 mode bit read");
    wr_aux(1'b1);
    check_reg(2'd0, ctrl_exp(), "R9 error unaffected");
    wr_ctrl(1'b1, 1'b0, 1'b1, 1'b1);
    wr_aux(1'b0);
    check_reg(2'd0, ctrl_exp(), "R9 mode kept");
    wr_aux(1'b1);
    check_reg(2'd0, ctrl_exp(), "R9 error kept");
    check_reg(2'd2, 8'h40, "R9 selector readback");
    wr_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
    wr_aux(1'b0);

    // R10 set wins over same-cycle clear
    send_frame(8'hE7, 1'b1, 1'b1, 0, '0, 1'b1, "R10 set wins"); sb_check();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule